// File: doc/BRIEF.md
# Single-Level Interrupt Context Controller

This block sits beside a small 8-bit microcontroller core and manages interrupt entry and return. It watches two request sources. The first is a timer rollover event. The second is a port of eight wakeup pins, each of which goes through an edge detector and sets its own pending flag. When an enabled request is pending and the core signals an instruction boundary, the block accepts the interrupt. It copies the program counter, working register, status register and file-select register into one shadow context. It then commands the core to fetch from address zero, with the page-select bits of the status register cleared. Further interrupts stay blocked until the handler returns.

Software finds the source by reading the pending flags and clears each flag with a write-one-to-clear strobe. The flags keep collecting edges while the handler runs. A return strobe makes the block write the whole saved context back into the core. Acceptance of new requests starts again one cycle after that write. There is no priority among sources and no nesting.

Top module: `irq_ctx_ctrl`

## Requirements
- R1: `tmr_pend_o` is set on the clock edge after `tmr_roll_i` is high. It stays set until a clock edge that sees `tmr_clr_i` high and `tmr_roll_i` low. When roll and clear arrive on the same edge, the flag stays set.
- R2: Each wakeup pin passes through two synchronizing flip-flops before edge detection. `wake_pol_i` bit value 0 selects a rising edge and value 1 selects a falling edge. A pin change applied before edge k sets its bit of `wake_pend_o` at edge k+2. A `wake_clr_i` bit clears the flag, except on the edge where a new edge on that pin sets it, in which case the flag stays set.
- R3: `irq_req_o` equals ((`tmr_pend_o` AND `tmr_ie_i`) OR any bit of (`wake_pend_o` AND `wake_en_i`)), forced low whenever `in_svc_o` is high. No source is favoured.
- R4: An interrupt is accepted at a clock edge where `irq_req_o` and `instr_bnd_i` are both high. That edge captures `pc_i`, `w_i`, `stat_i` and `fsr_i`. In the following cycle the block drives `pc_wr_o`=1 with `pc_wdata_o`=0, and `stat_wr_o`=1 with the captured status whose bits 7:5 (page select) are cleared. `w_wr_o` and `fsr_wr_o` stay low in that cycle.
- R5: `in_svc_o` rises in the cycle after acceptance and stays high until the restore cycle has ended. `irq_req_o` is low for that whole time.
- R6: Wakeup edges that occur while `in_svc_o` is high still set their pending flags. They cannot cause a second entry before the return.
- R7: A `reti_i` pulse while in service is followed, in the next cycle, by one cycle with all four write strobes high and the captured values on the write data ports. In the cycle after that, `in_svc_o` is low and requests are accepted again.
- R8: `reti_i` while not in service has no effect: no write strobe, and no change of `in_svc_o`.
- R9: After synchronous reset, all pending flags, `in_svc_o` and all write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_roll_i | input | 1 | Timer rollover event pulse |
| tmr_clr_i | input | 1 | Software clear of timer pending flag |
| tmr_ie_i | input | 1 | Timer interrupt enable |
| wake_pin_i | input | 8 | Asynchronous wakeup pins |
| wake_pol_i | input | 8 | Per-pin edge select: 0 rising, 1 falling |
| wake_en_i | input | 8 | Per-pin interrupt enable |
| wake_clr_i | input | 8 | Per-pin write-one-to-clear strobe |
| instr_bnd_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | 12 | Core program counter |
| w_i | input | 8 | Core working register |
| stat_i | input | 8 | Core status register |
| fsr_i | input | 8 | Core file-select register |
| irq_req_o | output | 1 | Masked interrupt request |
| in_svc_o | output | 1 | Handler in progress |
| tmr_pend_o | output | 1 | Timer pending flag |
| wake_pend_o | output | 8 | Wakeup pending flags |
| pc_wr_o | output | 1 | Program counter write strobe |
| pc_wdata_o | output | 12 | Program counter write value |
| w_wr_o | output | 1 | Working register write strobe |
| w_wdata_o | output | 8 | Working register write value |
| stat_wr_o | output | 1 | Status register write strobe |
| stat_wdata_o | output | 8 | Status register write value |
| fsr_wr_o | output | 1 | File-select register write strobe |
| fsr_wdata_o | output | 8 | File-select register write value |

## Verification
A corrupted sequencer state shows at the ports within one cycle. It appears either as a request that is not masked while `in_svc_o` is high, or as a write strobe in the wrong cycle. A wrong shadow value stays hidden until the restore cycle, when it appears on the write data ports. For that reason the bench changes the core inputs between entry and return. A wrong synchronizer depth or edge polarity moves or drops a pending flag. The cycle-accurate model catches this on the exact edge.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
    localparam int PC_W   = 12;
    localparam int DW     = 8;
    localparam int NPIN   = 8;
    localparam int PG_MSB = 7;
    localparam int PG_LSB = 5;
    localparam logic [DW-1:0] PG_MASK = DW'(((1 << (PG_MSB - PG_LSB + 1)) - 1) << PG_LSB);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_VECTOR  = 2'd1,
        ST_HANDLER = 2'd2,
        ST_RESTORE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   w;
        logic [DW-1:0]   stat;
        logic [DW-1:0]   fsr;
    } core_ctx_t;

    function automatic logic [DW-1:0] drop_page(input logic [DW-1:0] s);
        return s & ~PG_MASK;
    endfunction

    function automatic logic edge_seen(input logic fall_sel, input logic older, input logic newer);
        return fall_sel ? (older & ~newer) : (~older & newer);
    endfunction
endpackage

// File: rtl/irq_wake_edge.sv
module irq_wake_edge
    import irq_ctx_pkg::*;
#(
    parameter int NP = NPIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pin_i,
    input  logic [NP-1:0] pol_i,
    input  logic [NP-1:0] clr_i,
    output logic [NP-1:0] pend_o
);
    logic [NP-1:0] meta_q, sync_q, last_q, pend_q, hit;

    for (genvar g = 0; g < NP; g++) begin : g_pin
        assign hit[g] = edge_seen(pol_i[g], last_q[g], sync_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
            pend_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            last_q <= sync_q;
            pend_q <= (pend_q & ~clr_i) | hit;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctx_store.sv
module irq_ctx_store
    import irq_ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_i,
    input  core_ctx_t ctx_i,
    output core_ctx_t ctx_o
);
    core_ctx_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst)        shadow_q <= '0;
        else if (cap_i) shadow_q <= ctx_i;
    end

    assign ctx_o = shadow_q;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_req_i,
    input  logic       bnd_i,
    input  logic       reti_i,
    output seq_state_t st_o,
    output logic       take_o
);
    seq_state_t st_q, st_d;

    assign take_o = (st_q == ST_IDLE) && raw_req_i && bnd_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (take_o) st_d = ST_VECTOR;
            ST_VECTOR:  st_d = ST_HANDLER;
            ST_HANDLER: if (reti_i) st_d = ST_RESTORE;
            ST_RESTORE: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
    import irq_ctx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tmr_roll_i,
    input  logic            tmr_clr_i,
    input  logic            tmr_ie_i,
    input  logic [NPIN-1:0] wake_pin_i,
    input  logic [NPIN-1:0] wake_pol_i,
    input  logic [NPIN-1:0] wake_en_i,
    input  logic [NPIN-1:0] wake_clr_i,
    input  logic            instr_bnd_i,
    input  logic            reti_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [DW-1:0]   w_i,
    input  logic [DW-1:0]   stat_i,
    input  logic [DW-1:0]   fsr_i,
    output logic            irq_req_o,
    output logic            in_svc_o,
    output logic            tmr_pend_o,
    output logic [NPIN-1:0] wake_pend_o,
    output logic            pc_wr_o,
    output logic [PC_W-1:0] pc_wdata_o,
    output logic            w_wr_o,
    output logic [DW-1:0]   w_wdata_o,
    output logic            stat_wr_o,
    output logic [DW-1:0]   stat_wdata_o,
    output logic            fsr_wr_o,
    output logic [DW-1:0]   fsr_wdata_o
);
    logic       tmr_pend_q;
    logic       raw_req, take;
    seq_state_t st;
    core_ctx_t  live_ctx, saved_ctx;
    logic       in_vec, in_rest;

    always_ff @(posedge clk) begin
        if (rst) tmr_pend_q <= 1'b0;
        else     tmr_pend_q <= tmr_roll_i | (tmr_pend_q & ~tmr_clr_i);
    end

    irq_wake_edge #(.NP(NPIN)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (wake_pin_i),
        .pol_i  (wake_pol_i),
        .clr_i  (wake_clr_i),
        .pend_o (wake_pend_o)
    );

    assign raw_req = (tmr_pend_q & tmr_ie_i) | (|(wake_pend_o & wake_en_i));

    irq_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .raw_req_i (raw_req),
        .bnd_i     (instr_bnd_i),
        .reti_i    (reti_i),
        .st_o      (st),
        .take_o    (take)
    );

    assign live_ctx = '{pc: pc_i, w: w_i, stat: stat_i, fsr: fsr_i};

    irq_ctx_store u_store (
        .clk   (clk),
        .rst   (rst),
        .cap_i (take),
        .ctx_i (live_ctx),
        .ctx_o (saved_ctx)
    );

    assign in_vec  = (st == ST_VECTOR);
    assign in_rest = (st == ST_RESTORE);

    assign tmr_pend_o   = tmr_pend_q;
    assign in_svc_o     = (st != ST_IDLE);
    assign irq_req_o    = raw_req & ~in_svc_o;
    assign pc_wr_o      = in_vec | in_rest;
    assign pc_wdata_o   = in_vec ? '0 : saved_ctx.pc;
    assign stat_wr_o    = in_vec | in_rest;
    assign stat_wdata_o = in_vec ? drop_page(saved_ctx.stat) : saved_ctx.stat;
    assign w_wr_o       = in_rest;
    assign w_wdata_o    = saved_ctx.w;
    assign fsr_wr_o     = in_rest;
    assign fsr_wdata_o  = saved_ctx.fsr;
endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk
    import irq_ctx_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            tmr_clr_i,
    input logic            instr_bnd_i,
    input logic [NPIN-1:0] wake_clr_i,
    input logic            irq_req_o,
    input logic            in_svc_o,
    input logic            tmr_pend_o,
    input logic [NPIN-1:0] wake_pend_o,
    input logic            pc_wr_o,
    input logic [PC_W-1:0] pc_wdata_o,
    input logic            w_wr_o,
    input logic [DW-1:0]   stat_wdata_o
);
    assert_pend_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (tmr_pend_o && !tmr_clr_i) |=> tmr_pend_o);

    assert_wake_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ((~$past(wake_pend_o & ~wake_clr_i)) | wake_pend_o) == '1);

    assert_mask_in_svc_R5: assert property (@(posedge clk) disable iff (rst)
        in_svc_o |-> !irq_req_o);

    assert_vector_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_o && !w_wr_o) |-> (pc_wdata_o == '0 && stat_wdata_o[PG_MSB:PG_LSB] == '0));

    assert_entry_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_o && !w_wr_o) |-> $past(irq_req_o && instr_bnd_i));

    assert_restore_once_R7: assert property (@(posedge clk) disable iff (rst)
        w_wr_o |=> (!w_wr_o && !in_svc_o));
endmodule

bind irq_ctx_ctrl irq_ctx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tmr_clr_i    (tmr_clr_i),
    .instr_bnd_i  (instr_bnd_i),
    .wake_clr_i   (wake_clr_i),
    .irq_req_o    (irq_req_o),
    .in_svc_o     (in_svc_o),
    .tmr_pend_o   (tmr_pend_o),
    .wake_pend_o  (wake_pend_o),
    .pc_wr_o      (pc_wr_o),
    .pc_wdata_o   (pc_wdata_o),
    .w_wr_o       (w_wr_o),
    .stat_wdata_o (stat_wdata_o)
);

// File: tb/tb_irq_ctx_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctx_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_roll_i = 0, tmr_clr_i = 0, tmr_ie_i = 0;
    logic [7:0]  wake_pin_i = 0, wake_pol_i = 0, wake_en_i = 0, wake_clr_i = 0;
    logic        instr_bnd_i = 0, reti_i = 0;
    logic [11:0] pc_i = 0;
    logic [7:0]  w_i = 0, stat_i = 0, fsr_i = 0;
    logic        irq_req_o, in_svc_o, tmr_pend_o;
    logic [7:0]  wake_pend_o;
    logic        pc_wr_o, w_wr_o, stat_wr_o, fsr_wr_o;
    logic [11:0] pc_wdata_o;
    logic [7:0]  w_wdata_o, stat_wdata_o, fsr_wdata_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    irq_ctx_ctrl dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Behavioural reference: mode 0 idle, 1 vector, 2 handler, 3 restore
    int          m_mode;
    logic        m_tp;
    logic [7:0]  m_wp;
    logic [11:0] m_pc;
    logic [7:0]  m_w, m_st, m_fsr;
    logic [7:0]  hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_tp = 0; m_wp = 0;
            m_pc = 0; m_w = 0; m_st = 0; m_fsr = 0;
            hist = '{8'h00, 8'h00, 8'h00};
        end else begin
            logic req;
            logic [7:0] e;
            req = (m_mode == 0) && ((m_tp && tmr_ie_i) || ((m_wp & wake_en_i) != 0));
            hist.push_front(wake_pin_i);
            for (int i = 0; i < 8; i++)
                e[i] = wake_pol_i[i] ? (hist[3][i] && !hist[2][i]) : (!hist[3][i] && hist[2][i]);
            void'(hist.pop_back());
            m_tp = tmr_roll_i || (m_tp && !tmr_clr_i);
            m_wp = (m_wp & ~wake_clr_i) | e;
            case (m_mode)
                0: if (req && instr_bnd_i) begin
                       m_pc = pc_i; m_w = w_i; m_st = stat_i; m_fsr = fsr_i; m_mode = 1;
                   end
                1: m_mode = 2;
                2: if (reti_i) m_mode = 3;
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic ereq;
            ereq = (m_mode == 0) && ((m_tp && tmr_ie_i) || ((m_wp & wake_en_i) != 0));
            chk("R1 tmr_pend_o", tmr_pend_o, m_tp);
            chk("R2 wake_pend_o", wake_pend_o, m_wp);
            chk("R3 irq_req_o", irq_req_o, ereq);
            chk("R5 in_svc_o", in_svc_o, m_mode != 0);
            chk("R4 R7 pc_wr_o", pc_wr_o, m_mode == 1 || m_mode == 3);
            chk("R4 R7 stat_wr_o", stat_wr_o, m_mode == 1 || m_mode == 3);
            chk("R7 w_wr_o", w_wr_o, m_mode == 3);
            chk("R7 fsr_wr_o", fsr_wr_o, m_mode == 3);
            if (m_mode == 1) begin
                chk("R4 vector pc", pc_wdata_o, 0);
                chk("R4 page clear", stat_wdata_o, m_st & 8'h1F);
            end
            if (m_mode == 3) begin
                chk("R7 pc restore", pc_wdata_o, m_pc);
                chk("R7 w restore", w_wdata_o, m_w);
                chk("R7 stat restore", stat_wdata_o, m_st);
                chk("R7 fsr restore", fsr_wdata_o, m_fsr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        // R9 reset state
        chk("R9 in_svc", in_svc_o, 0);
        chk("R9 pend", {tmr_pend_o, wake_pend_o}, 0);
        chk("R9 strobes", {pc_wr_o, w_wr_o, stat_wr_o, fsr_wr_o}, 0);

        pc_i = 12'hA5C; w_i = 8'h3C; stat_i = 8'hFF; fsr_i = 8'h81;
        tmr_roll_i = 1; cyc(); tmr_roll_i = 0; cyc();
        chk("R1 timer pend set", tmr_pend_o, 1);
        chk("R3 disabled no req", irq_req_o, 0);
        tmr_ie_i = 1; #1;
        chk("R3 enabled req", irq_req_o, 1);
        cyc(2);
        chk("R4 no boundary no entry", in_svc_o, 0);
        instr_bnd_i = 1; cyc(); instr_bnd_i = 0;
        chk("R4 vector pc write", {pc_wr_o, pc_wdata_o}, {1'b1, 12'h000});
        chk("R4 status page cleared", {stat_wr_o, stat_wdata_o}, {1'b1, 8'h1F});
        chk("R4 no w write at entry", w_wr_o, 0);
        pc_i = 12'h123; w_i = 8'h00; stat_i = 8'h00; fsr_i = 8'h00;
        cyc();
        chk("R5 in service", {in_svc_o, irq_req_o}, 2'b10);
        wake_en_i = 8'hFF; wake_pin_i[2] = 1; instr_bnd_i = 1; cyc(4);
        chk("R6 flag collected in handler", wake_pend_o[2], 1);
        chk("R6 no nested entry", {in_svc_o, irq_req_o, pc_wr_o}, 3'b100);
        instr_bnd_i = 0; reti_i = 1; cyc(); reti_i = 0;
        chk("R7 restore pc", {pc_wr_o, pc_wdata_o}, {1'b1, 12'hA5C});
        chk("R7 restore w fsr", {w_wr_o, w_wdata_o, fsr_wr_o, fsr_wdata_o}, {1'b1, 8'h3C, 1'b1, 8'h81});
        chk("R7 restore stat", stat_wdata_o, 8'hFF);
        cyc();
        chk("R7 rearmed", {in_svc_o, irq_req_o}, 2'b01);
        tmr_clr_i = 1; wake_clr_i = 8'hFF; cyc();
        tmr_clr_i = 0; wake_clr_i = 0;
        chk("R1 cleared", {tmr_pend_o, wake_pend_o}, 0);

        reti_i = 1; cyc(); reti_i = 0;
        chk("R8 stray return ignored", {in_svc_o, pc_wr_o, w_wr_o}, 0);
        cyc();
        chk("R8 still idle", in_svc_o, 0);

        wake_pol_i[4] = 1; wake_pin_i[4] = 1; cyc(4);
        chk("R2 rising ignored on falling pin", wake_pend_o[4], 0);
        wake_pin_i[4] = 0; cyc(2);
        wake_clr_i[4] = 1; cyc(); wake_clr_i[4] = 0;
        chk("R2 edge beats clear", wake_pend_o[4], 1);
        wake_clr_i[4] = 1; cyc(); wake_clr_i[4] = 0;
        chk("R2 clear works", wake_pend_o[4], 0);

        for (int k = 0; k < 3000; k++) begin
            tmr_roll_i  = ($urandom_range(0, 15) == 0);
            tmr_clr_i   = ($urandom_range(0, 7) == 0);
            tmr_ie_i    = $urandom_range(0, 1);
            if ($urandom_range(0, 3) == 0) wake_pin_i = 8'($urandom);
            if ($urandom_range(0, 31) == 0) wake_pol_i = 8'($urandom);
            wake_en_i   = 8'($urandom);
            wake_clr_i  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
            instr_bnd_i = $urandom_range(0, 1);
            reti_i      = ($urandom_range(0, 5) == 0);
            pc_i = 12'($urandom); w_i = 8'($urandom); stat_i = 8'($urandom); fsr_i = 8'($urandom);
            cyc();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule